// File: doc/BRIEF.md
# Receive FIFO Interrupt and Character Timeout Controller

This block produces the status and interrupt conditions for the receive side of a UART whose received characters wait in a 16-entry FIFO. It watches the FIFO occupancy, a strobe for each character the deserializer pushes, a strobe for each character the CPU reads, and an error flag that travels with each pushed character. From these it derives four results: a data-ready flag, an error summary for the characters held in the FIFO, a trigger-level condition, and a character timeout. It also produces one prioritized receive interrupt identification code.

The character timeout catches a partial burst that stays below the trigger level. It fires when the FIFO holds data and no character has arrived and none has been read for four character times. A character time is counted in 16x baud-clock ticks and scaled by the programmed frame length, so the delay follows the baud rate and includes a second stop bit when one is configured. Clearing the interrupt enables gives polled operation. The status flags stay valid, and no trigger-level or timeout condition is raised.

Top module: `rx_fifo_irq_ctrl`

## Requirements
- R1: `data_ready_o` is 1 in the same cycle that `fifo_count_i` is non-zero and 0 whenever it is zero. It is 0 during reset.
- R2: `trig_sel_i` selects the trigger level: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. `trig_o` is 1 while `ien_data_i` is 1 and `fifo_count_i` is at or above the selected level. It drops in the same cycle that the count falls below that level.
- R3: `err_any_o` becomes 1 one clock edge after a character is pushed with `rx_push_err_i` = 1. It stays 1 while any errored character remains in the FIFO and falls one edge after the last errored character is read.
- R4: When the character at the FIFO head carries an error and `ien_line_i` = 1, `iid_o` is 4'h6. This code wins over the trigger-level and timeout codes.
- R5: The timeout threshold is 64 × `frame_bits_i` baud ticks. `timeout_o` is 1 when `ien_data_i` = 1, the FIFO is non-empty and that many ticks have elapsed since the last restart. In that state, if the trigger level is not met and R4 does not apply, `iid_o` is 4'hC.
- R6: Every push or CPU read restarts the timeout count, and `timeout_o` is 0 after that edge. A read also clears a timeout that has already fired.
- R7: The priority from highest to lowest is: line error 4'h6, trigger level 4'h4, timeout 4'hC, none 4'h1. `irq_o` is 1 exactly when `iid_o` is not 4'h1.
- R8: With `ien_data_i` = 0, `trig_o` and `timeout_o` are 0 and neither 4'h4 nor 4'hC is reported. With `ien_line_i` = 0, 4'h6 is not reported. In both cases `data_ready_o` and `err_any_o` keep their normal behaviour.
- R9: The threshold follows the frame length. A 12-bit frame (two stop bits included) times out after exactly 768 ticks, and a 7-bit frame after exactly 448 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| fifo_count_i | input | 5 | Current receive FIFO occupancy |
| rx_push_i | input | 1 | A character enters the FIFO this cycle |
| rx_push_err_i | input | 1 | Error flag of the character being pushed |
| rx_read_i | input | 1 | The CPU reads one character this cycle |
| trig_sel_i | input | 2 | Trigger level select |
| frame_bits_i | input | 4 | Bits per frame: start, data, parity and stop |
| ien_data_i | input | 1 | Enables the trigger-level and timeout interrupts |
| ien_line_i | input | 1 | Enables the line error interrupt |
| data_ready_o | output | 1 | At least one character is held |
| err_any_o | output | 1 | Some held character carries an error |
| trig_o | output | 1 | Trigger level reached (enabled) |
| timeout_o | output | 1 | Character timeout (enabled) |
| irq_o | output | 1 | Receive interrupt pending |
| iid_o | output | 4 | Interrupt identification code |

## Verification
Data-ready, trigger level, the line-error code and the identification code follow `fifo_count_i`, the enables and the registered head error flag through logic alone. They are due in the same cycle as the inputs. The error summary is due one edge after the push or read that changes it. The timeout is due right after the edge that carries the threshold-th baud tick since the last push or read. The bench drives every input on the falling edge, compares one time unit later against a model of the queue and tick count, and advances that model only on the rising edge. Each comparison therefore sees exactly the state the design has registered. The directed timeout cases check the cycle one tick before the threshold and the cycle that reaches it.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_LINE = 4'h6,
    IID_DATA = 4'h4,
    IID_CTO  = 4'hC
  } iid_e;

  // occupancy level selected by the 2-bit trigger field
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_err_i,
  input  logic pop_i,
  output logic head_err_o,
  output logic err_any_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] flag_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] ecnt_q;
  logic             inc, dec;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign inc = push_i && push_err_i;
  assign dec = pop_i && flag_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      ecnt_q <= '0;
    end else begin
      if (push_i) begin
        flag_q[wr_q] <= push_err_i;
        wr_q         <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      case ({inc, dec})
        2'b10:   ecnt_q <= ecnt_q + 1'b1;
        2'b01:   ecnt_q <= ecnt_q - 1'b1;
        default: ecnt_q <= ecnt_q;
      endcase
    end
  end

  assign head_err_o = flag_q[rd_q];
  assign err_any_o  = (ecnt_q != '0);

endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int unsigned FRAME_W       = 4,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned TO_CHARS      = 4,
  parameter int unsigned TMR_W         = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               restart_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  output logic               expired_o
);
  localparam int unsigned SCALE = TICKS_PER_BIT * TO_CHARS;

  logic [TMR_W-1:0] thr, tmr_q;

  assign thr = TMR_W'(frame_bits_i) * TMR_W'(SCALE);

  // saturates at the threshold so the condition holds until a restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tmr_q <= '0;
    else if (restart_i)           tmr_q <= '0;
    else if (tick_i && tmr_q < thr) tmr_q <= tmr_q + 1'b1;
  end

  assign expired_o = (tmr_q >= thr);

endmodule

// File: rtl/rx_irq_prio.sv
module rx_irq_prio
  import rx_irq_pkg::*;
(
  input  logic line_req_i,
  input  logic data_req_i,
  input  logic cto_req_i,
  output iid_e iid_o,
  output logic irq_o
);
  always_comb begin
    if (line_req_i)      iid_o = IID_LINE;
    else if (data_req_i) iid_o = IID_DATA;
    else if (cto_req_i)  iid_o = IID_CTO;
    else                 iid_o = IID_NONE;
  end

  assign irq_o = line_req_i || data_req_i || cto_req_i;

endmodule

// File: rtl/rx_fifo_irq_ctrl.sv
module rx_fifo_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned FRAME_W       = 4,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned TO_CHARS      = 4,
  localparam int unsigned CNT_W        = $clog2(DEPTH + 1),
  localparam int unsigned TMR_W        = $clog2(TICKS_PER_BIT * TO_CHARS * ((1 << FRAME_W) - 1) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               baud_tick_i,
  input  logic [CNT_W-1:0]   fifo_count_i,
  input  logic               rx_push_i,
  input  logic               rx_push_err_i,
  input  logic               rx_read_i,
  input  logic [1:0]         trig_sel_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               ien_data_i,
  input  logic               ien_line_i,
  output logic               data_ready_o,
  output logic               err_any_o,
  output logic               trig_o,
  output logic               timeout_o,
  output logic               irq_o,
  output logic [3:0]         iid_o
);
  logic             nonempty, head_err, tmr_expired, line_req;
  logic [CNT_W-1:0] trig_lvl;
  iid_e             iid;

  assign nonempty = (fifo_count_i != '0);
  assign trig_lvl = CNT_W'(trig_level(trig_sel_i, DEPTH));

  rx_err_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_push_i),
    .push_err_i (rx_push_err_i),
    .pop_i      (rx_read_i),
    .head_err_o (head_err),
    .err_any_o  (err_any_o)
  );

  rx_char_timer #(
    .FRAME_W(FRAME_W), .TICKS_PER_BIT(TICKS_PER_BIT),
    .TO_CHARS(TO_CHARS), .TMR_W(TMR_W)
  ) u_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (baud_tick_i),
    .restart_i    (rx_push_i || rx_read_i),
    .frame_bits_i (frame_bits_i),
    .expired_o    (tmr_expired)
  );

  assign data_ready_o = nonempty;
  assign trig_o       = ien_data_i && (fifo_count_i >= trig_lvl);
  assign timeout_o    = ien_data_i && nonempty && tmr_expired;
  assign line_req     = ien_line_i && nonempty && head_err;

  rx_irq_prio u_prio (
    .line_req_i (line_req),
    .data_req_i (trig_o),
    .cto_req_i  (timeout_o),
    .iid_o      (iid),
    .irq_o      (irq_o)
  );

  assign iid_o = iid;

endmodule

// File: rtl/rx_fifo_irq_ctrl_sva.sv
module rx_fifo_irq_ctrl_sva #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned FRAME_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CNT_W-1:0]   fifo_count_i,
  input logic               rx_push_i,
  input logic               rx_push_err_i,
  input logic               rx_read_i,
  input logic [FRAME_W-1:0] frame_bits_i,
  input logic               ien_data_i,
  input logic               ien_line_i,
  input logic               head_err_i,
  input logic               data_ready_o,
  input logic               err_any_o,
  input logic               trig_o,
  input logic               timeout_o,
  input logic               irq_o,
  input logic [3:0]         iid_o
);
  a_r3_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && rx_push_err_i |=> err_any_o);

  a_r4_line_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_line_i && head_err_i && fifo_count_i != '0 |-> iid_o == 4'h6);

  a_r5_timeout_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i || rx_read_i) && frame_bits_i != '0 |=> !timeout_o);

  a_r7_irq_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iid_o != 4'h1));

  a_r8_polled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_data_i |-> !trig_o && !timeout_o && iid_o != 4'h4 && iid_o != 4'hC);

endmodule

bind rx_fifo_irq_ctrl rx_fifo_irq_ctrl_sva #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fifo_count_i  (fifo_count_i),
  .rx_push_i     (rx_push_i),
  .rx_push_err_i (rx_push_err_i),
  .rx_read_i     (rx_read_i),
  .frame_bits_i  (frame_bits_i),
  .ien_data_i    (ien_data_i),
  .ien_line_i    (ien_line_i),
  .head_err_i    (head_err),
  .data_ready_o  (data_ready_o),
  .err_any_o     (err_any_o),
  .trig_o        (trig_o),
  .timeout_o     (timeout_o),
  .irq_o         (irq_o),
  .iid_o         (iid_o)
);

// File: tb/tb_rx_fifo_irq_ctrl.sv
module tb_rx_fifo_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CW         = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       baud_tick_i, rx_push_i, rx_push_err_i, rx_read_i;
  logic [CW-1:0] fifo_count_i;
  logic [1:0] trig_sel_i;
  logic [3:0] frame_bits_i;
  logic       ien_data_i, ien_line_i;
  logic       data_ready_o, err_any_o, trig_o, timeout_o, irq_o;
  logic [3:0] iid_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_fifo_irq_ctrl dut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit m_q[$];
  int m_tmr  = 0;

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int thr_of(input logic [3:0] f);
    return int'(f) * 64;
  endfunction

  function automatic logic [3:0] exp_iid();
    int n = m_q.size();
    if (ien_line_i && n > 0 && m_q[0]) return 4'h6;
    if (ien_data_i && n >= lvl(trig_sel_i)) return 4'h4;
    if (ien_data_i && n > 0 && m_tmr >= thr_of(frame_bits_i)) return 4'hC;
    return 4'h1;
  endfunction

  function automatic bit exp_err();
    bit e = 0;
    foreach (m_q[i]) e |= m_q[i];
    return e;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int n = m_q.size();
    chk("R1", "data_ready", int'(data_ready_o), int'(n != 0));
    chk("R2", "trig", int'(trig_o), int'(ien_data_i && n >= lvl(trig_sel_i)));
    chk("R3", "err_any", int'(err_any_o), int'(exp_err()));
    chk("R5", "timeout", int'(timeout_o),
        int'(ien_data_i && n > 0 && m_tmr >= thr_of(frame_bits_i)));
    chk("R7", "iid", int'(iid_o), int'(exp_iid()));
    chk("R7", "irq", int'(irq_o), int'(exp_iid() != 4'h1));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit push, input bit err, input bit rd, input bit tick);
    int thr;
    rx_push_i     = push;
    rx_push_err_i = err;
    rx_read_i     = rd;
    baud_tick_i   = tick;
    fifo_count_i  = CW'(m_q.size());
    #1;
    check_all();
    @(posedge clk_i);
    thr = thr_of(frame_bits_i);
    if (push || rd) m_tmr = 0;
    else if (tick && m_tmr < thr) m_tmr++;
    if (rd) void'(m_q.pop_front());
    if (push) m_q.push_back(err);
    @(negedge clk_i);
  endtask

  task automatic settle();
    rx_push_i = 0; rx_read_i = 0; baud_tick_i = 0; rx_push_err_i = 0;
    fifo_count_i = CW'(m_q.size());
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 0;
    rx_push_i = 0; rx_push_err_i = 0; rx_read_i = 0; baud_tick_i = 0;
    fifo_count_i = '0; trig_sel_i = 2'd1; frame_bits_i = 4'd7;
    ien_data_i = 1; ien_line_i = 1;
    repeat (2) @(negedge clk_i);
    #1;
    chk("R1", "reset data_ready", int'(data_ready_o), 0);
    chk("R3", "reset err_any", int'(err_any_o), 0);
    chk("R7", "reset iid", int'(iid_o), 1);
    chk("R5", "reset timeout", int'(timeout_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 / R2: trigger level 4
    step(1, 0, 0, 0); settle();
    chk("R1", "ready after push", int'(data_ready_o), 1);
    chk("R2", "trig at 1 of 4", int'(trig_o), 0);
    repeat (3) step(1, 0, 0, 0);
    settle();
    chk("R2", "trig at 4 of 4", int'(trig_o), 1);
    chk("R7", "iid data", int'(iid_o), 4);
    step(0, 0, 1, 0); settle();
    chk("R2", "trig below level", int'(trig_o), 0);

    // R5: 7-bit frame, 448 ticks
    repeat (447) step(0, 0, 0, 1);
    settle();
    chk("R5", "no timeout at 447", int'(timeout_o), 0);
    step(0, 0, 0, 1); settle();
    chk("R5", "timeout at 448", int'(timeout_o), 1);
    chk("R5", "iid timeout", int'(iid_o), 12);

    // R8: polled mode hides it
    ien_data_i = 0; settle();
    chk("R8", "polled timeout", int'(timeout_o), 0);
    chk("R8", "polled iid", int'(iid_o), 1);
    chk("R8", "polled ready", int'(data_ready_o), 1);
    ien_data_i = 1;

    // R6: read clears a fired timeout
    step(0, 0, 1, 0); settle();
    chk("R6", "timeout cleared by read", int'(timeout_o), 0);

    // R3 / R4: error character behind clean ones
    step(1, 1, 0, 0); settle();
    chk("R3", "err_any set", int'(err_any_o), 1);
    chk("R4", "no line code, clean head", int'(iid_o == 4'h6), 0);
    repeat (2) step(0, 0, 1, 0);
    settle();
    chk("R4", "line code at head", int'(iid_o), 6);
    trig_sel_i = 2'd0; settle();
    chk("R4", "line over trigger", int'(iid_o), 6);
    ien_line_i = 0; settle();
    chk("R8", "line disabled", int'(iid_o), 4);
    chk("R3", "err_any still", int'(err_any_o), 1);
    ien_line_i = 1; trig_sel_i = 2'd1;
    step(0, 0, 1, 0); settle();
    chk("R3", "err_any cleared", int'(err_any_o), 0);
    chk("R1", "ready cleared", int'(data_ready_o), 0);

    // R9: 12-bit frame, 768 ticks
    frame_bits_i = 4'd12;
    step(1, 0, 0, 0);
    repeat (767) step(0, 0, 0, 1);
    settle();
    chk("R9", "no timeout at 767", int'(timeout_o), 0);
    step(0, 0, 0, 1); settle();
    chk("R9", "timeout at 768", int'(timeout_o), 1);
    step(1, 0, 0, 1); settle();
    chk("R6", "push restarts", int'(timeout_o), 0);

    // R2: level 14 boundary
    trig_sel_i = 2'd3;
    repeat (11) step(1, 0, 0, 0);
    settle();
    chk("R2", "trig at 13 of 14", int'(trig_o), 0);
    step(1, 0, 0, 0); settle();
    chk("R2", "trig at 14 of 14", int'(trig_o), 1);
    trig_sel_i = 2'd2; settle();
    chk("R2", "trig level 8 met", int'(trig_o), 1);
    while (m_q.size() > 0) step(0, 0, 1, 0);

    // random blocks, busy or idle
    for (int b = 0; b < 10; b++) begin
      bit idle;
      idle         = ($urandom % 3) == 0;
      ien_data_i   = ($urandom % 4) != 0;
      ien_line_i   = ($urandom % 4) != 0;
      trig_sel_i   = 2'($urandom);
      frame_bits_i = 4'(7 + $urandom % 6);
      for (int k = 0; k < 800; k++) begin
        int n;
        bit p, r;
        n = m_q.size();
        p = 0; r = 0;
        if (!idle) begin
          p = (n < DEPTH) && ($urandom % 8 == 0);
          r = (n > 0) && ($urandom % 8 == 0);
        end
        step(p, 1'($urandom), r, ($urandom % 4) != 0);
      end
    end
    settle();
    finish_run();
  end

endmodule